// File: doc/BRIEF.md
# Two-Bank Interleaved Instruction Prefetcher

This block feeds instruction words to a small in-order core whose fetch, decode and execute stages each take one clock. The program store behind it is slow: it is split into two banks, and each bank needs two core clocks per access. Words at even word addresses live in the even bank and words at odd addresses in the odd bank. The prefetcher alternates between the banks, so a run of sequential fetches delivers one word per clock, even though neither bank could keep up alone.

Fetched words wait in a four-entry register FIFO until the core takes them through a valid/ready handshake. When the core takes a branch, it presents the target on the redirect port. The FIFO is emptied, any access still in flight is marked stale by an epoch bit and its data is thrown away, and fetching starts again at the target. Only the first word after a redirect pays the memory wait. After it, the stream continues at one word per clock whichever bank the target falls in. Out of reset, fetching starts at a parameter-defined start address.

Top module: `ilv_prefetch`

## Requirements
- R1: While reset is held, `out_valid` is low. If reset is released before a clock edge, the word at `RESET_VEC` is presented on the output in the third cycle after that edge, with no valid word before it.
- R2: Word address A is fetched from the bank selected by bit 0 of A (0 = even bank, 1 = odd bank). The row address is A[AW-1:1]. The output pairs each word with its own word address.
- R3: A bank is never requested in two consecutive cycles.
- R4: If a redirect is sampled at the end of cycle r, the target word is on the output in cycle r+4, provided the core was ready.
- R5: While the core stays ready, the words after a redirect target arrive one per cycle, in increasing address order.
- R6: An odd target starts in the odd bank and keeps the same one-per-cycle stream as an even target.
- R7: The FIFO never holds more than 4 words. When the core stops taking words, the block issues exactly 4 fetches after a redirect and then waits. No word is lost or reordered when the core resumes.
- R8: In the cycle after a redirect, `out_valid` is low. No word fetched before the redirect ever appears on the output afterwards.
- R9: A bank response to a request issued before a redirect is dropped, even when it returns after the redirect.
- R10: While `out_valid` is high, `out_ready` is low and no redirect is present, the next cycle shows the same word and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_vld | input | 1 | Branch taken: flush and restart |
| redirect_addr | input | AW | Branch target word address |
| out_valid | output | 1 | An instruction word is offered |
| out_ready | input | 1 | Core accepts the offered word |
| out_addr | output | AW | Word address of the offered word |
| out_data | output | DW | Offered instruction word |
| even_req | output | 1 | Access request to the even bank |
| even_row | output | AW-1 | Row address for the even bank |
| even_rsp_vld | input | 1 | Even bank returns data |
| even_rsp_data | input | DW | Even bank read data |
| odd_req | output | 1 | Access request to the odd bank |
| odd_row | output | AW-1 | Row address for the odd bank |
| odd_rsp_vld | input | 1 | Odd bank returns data |
| odd_rsp_data | input | DW | Odd bank read data |

## Verification
The response-alignment check assumes that each bank answers a request exactly two clocks later, with a single valid pulse and no unsolicited responses. The bench memory is a two-stage pipeline per bank that is reset together with the block, so it cannot answer early, late or unprompted. Other checks rely on the core holding its inputs steady between clock edges. The bench changes `out_ready` and the redirect inputs only at falling edges.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // two banks, each answering a request two core cycles after it is issued
  localparam int unsigned NBANK    = 2;
  localparam int unsigned BANK_LAT = 2;
endpackage

// File: rtl/ilv_word_fifo.sv
module ilv_word_fifo #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  input  logic                         flush,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0][W-1:0] slot_q;
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = bump(wr_q);
      if (pop)  rd_d = bump(rd_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage words carry no reset; write enable spelled out
  always_ff @(posedge clk) begin
    if (push && !flush) slot_q[wr_q] <= wdata;
  end

  assign rdata = slot_q[rd_q];
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (cnt_q != FULL || pop));

  assert_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
endmodule

// File: rtl/ilv_issue_ctl.sv
module ilv_issue_ctl
  import ilv_pkg::*;
#(
  parameter int unsigned    AW        = 16,
  parameter int unsigned    DEPTH     = 4,
  parameter logic [AW-1:0]  RESET_VEC = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        redir_vld,
  input  logic [AW-1:0]               redir_addr,
  input  logic [$clog2(DEPTH+1)-1:0]  fifo_count,
  output logic                        issue_vld,
  output logic [AW-1:0]               issue_addr,
  output logic                        ret_pend,
  output logic                        ret_live,
  output logic [AW-1:0]               ret_addr
);
  localparam int unsigned SW = $clog2(DEPTH + BANK_LAT + 1);
  localparam logic [SW-1:0] DEPTH_W = SW'(DEPTH);

  logic [AW-1:0] fpc_q, fpc_d;
  logic          ep_q, ep_d;
  logic [BANK_LAT-1:0]         sv_q, sv_d, sep_q, sep_d;
  logic [BANK_LAT-1:0][AW-1:0] sa_q, sa_d;
  logic          busy;
  logic [SW-1:0] occ;

  // the target bank is busy while an earlier access to it is still in its first cycle
  always_comb begin
    busy = 1'b0;
    for (int k = 0; k < int'(BANK_LAT) - 1; k++) begin
      if (sv_q[k] && (sa_q[k][0] == fpc_q[0])) busy = 1'b1;
    end
  end

  // buffered words plus live in-flight accesses must leave room for one more
  always_comb begin
    occ = SW'(fifo_count);
    for (int k = 0; k < int'(BANK_LAT); k++) begin
      occ = occ + SW'(sv_q[k] && (sep_q[k] == ep_q));
    end
  end

  assign issue_vld  = !redir_vld && !busy && (occ < DEPTH_W);
  assign issue_addr = fpc_q;

  always_comb begin
    fpc_d = fpc_q;
    ep_d  = ep_q;
    if (redir_vld) begin
      fpc_d = redir_addr;
      ep_d  = ~ep_q;
    end else if (issue_vld) begin
      fpc_d = fpc_q + 1'b1;
    end
    sv_d  = {sv_q[BANK_LAT-2:0], issue_vld};
    sep_d = {sep_q[BANK_LAT-2:0], ep_q};
    sa_d  = {sa_q[BANK_LAT-2:0], fpc_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpc_q <= RESET_VEC;
      ep_q  <= 1'b0;
      sv_q  <= '0;
      sep_q <= '0;
      sa_q  <= '0;
    end else begin
      fpc_q <= fpc_d;
      ep_q  <= ep_d;
      sv_q  <= sv_d;
      sep_q <= sep_d;
      sa_q  <= sa_d;
    end
  end

  assign ret_pend = sv_q[BANK_LAT-1];
  assign ret_live = sv_q[BANK_LAT-1] && (sep_q[BANK_LAT-1] == ep_q);
  assign ret_addr = sa_q[BANK_LAT-1];

  assert_bank_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> !(issue_vld && (issue_addr[0] == $past(issue_addr[0]))));

  assert_stale_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |=> !ret_live);
endmodule

// File: rtl/ilv_prefetch.sv
module ilv_prefetch
  import ilv_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   DW        = 32,
  parameter int unsigned   DEPTH     = 4,
  parameter logic [AW-1:0] RESET_VEC = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_vld,
  input  logic [AW-1:0] redirect_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic          even_req,
  output logic [AW-2:0] even_row,
  input  logic          even_rsp_vld,
  input  logic [DW-1:0] even_rsp_data,
  output logic          odd_req,
  output logic [AW-2:0] odd_row,
  input  logic          odd_rsp_vld,
  input  logic [DW-1:0] odd_rsp_data
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = AW + DW;

  logic          issue_vld, ret_pend, ret_live;
  logic [AW-1:0] issue_addr, ret_addr;
  logic [CW-1:0] fifo_count;
  logic          push, pop, empty;
  logic [EW-1:0] rd_entry;
  logic [NBANK-1:0]         bank_req, bank_rsp_vld;
  logic [NBANK-1:0][DW-1:0] bank_rsp_data;

  ilv_issue_ctl #(.AW(AW), .DEPTH(DEPTH), .RESET_VEC(RESET_VEC)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .redir_vld  (redirect_vld),
    .redir_addr (redirect_addr),
    .fifo_count (fifo_count),
    .issue_vld  (issue_vld),
    .issue_addr (issue_addr),
    .ret_pend   (ret_pend),
    .ret_live   (ret_live),
    .ret_addr   (ret_addr)
  );

  // bank select is the low word-address bit; the row is the remaining bits
  for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
    assign bank_req[b] = issue_vld && (issue_addr[0] == 1'(b));

    assert_rsp_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bank_rsp_vld[b] == (ret_pend && (ret_addr[0] == 1'(b))));
  end

  assign even_req         = bank_req[0];
  assign odd_req          = bank_req[1];
  assign even_row         = issue_addr[AW-1:1];
  assign odd_row          = issue_addr[AW-1:1];
  assign bank_rsp_vld     = {odd_rsp_vld, even_rsp_vld};
  assign bank_rsp_data[0] = even_rsp_data;
  assign bank_rsp_data[1] = odd_rsp_data;

  assign push = ret_live && !redirect_vld;
  assign pop  = out_valid && out_ready;

  ilv_word_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata ({ret_addr, bank_rsp_data[ret_addr[0]]}),
    .pop   (pop),
    .flush (redirect_vld),
    .rdata (rd_entry),
    .empty (empty),
    .count (fifo_count)
  );

  assign out_valid = !empty;
  assign out_addr  = rd_entry[EW-1:DW];
  assign out_data  = rd_entry[DW-1:0];

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |=> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !redirect_vld) |=>
      (out_valid && $stable(out_data) && $stable(out_addr)));
endmodule

// File: tb/tb_ilv_prefetch.sv
module tb_ilv_prefetch;
  localparam logic [15:0] RV = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redirect_vld = 1'b0;
  logic [15:0] redirect_addr = '0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [15:0] out_addr;
  logic [31:0] out_data;
  logic even_req, odd_req, even_rsp_vld, odd_rsp_vld;
  logic [14:0] even_row, odd_row;
  logic [31:0] even_rsp_data, odd_rsp_data;

  always #4 clk = ~clk;

  function automatic logic [31:0] mkdata(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  ilv_prefetch #(.AW(16), .DW(32), .DEPTH(4), .RESET_VEC(RV)) dut (
    .clk(clk), .rst_n(rst_n),
    .redirect_vld(redirect_vld), .redirect_addr(redirect_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data),
    .even_req(even_req), .even_row(even_row),
    .even_rsp_vld(even_rsp_vld), .even_rsp_data(even_rsp_data),
    .odd_req(odd_req), .odd_row(odd_row),
    .odd_rsp_vld(odd_rsp_vld), .odd_rsp_data(odd_rsp_data)
  );

  // behavioural bank memory: answers exactly two cycles after a request
  logic [1:0]  mv1, mv2;
  logic [14:0] er1, er2, or1, or2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv1 <= '0; mv2 <= '0;
      er1 <= '0; er2 <= '0; or1 <= '0; or2 <= '0;
    end else begin
      mv1 <= {odd_req, even_req};
      mv2 <= mv1;
      er1 <= even_row; er2 <= er1;
      or1 <= odd_row;  or2 <= or1;
    end
  end
  assign even_rsp_vld  = mv2[0];
  assign odd_rsp_vld   = mv2[1];
  assign even_rsp_data = mkdata({er2, 1'b0});
  assign odd_rsp_data  = mkdata({or2, 1'b1});

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic nx_ready = 1'b0, nx_redir = 1'b0, nx_rst = 1'b0;
  logic [15:0] nx_addr = '0;
  logic [15:0] exp_addr = RV;
  logic [1:0] prev_req = '0;
  bit hold_pend = 1'b0;
  logic [15:0] hold_addr;
  logic [31:0] hold_data;
  int reqs_since = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive inputs at the falling edge, then check against the model
  task automatic tick();
    @(negedge clk);
    rst_n = nx_rst;
    out_ready = nx_ready;
    redirect_vld = nx_redir;
    redirect_addr = nx_addr;
    #1;
    if (rst_n) begin
      if (even_req) chk(!prev_req[0], "R3 even bank back-to-back", 1, 0);
      if (odd_req)  chk(!prev_req[1], "R3 odd bank back-to-back", 1, 0);
      if (hold_pend)
        chk(out_valid && out_addr == hold_addr && out_data == hold_data,
            "R10 stalled word changed", {out_valid, out_addr, out_data}, {1'b1, hold_addr, hold_data});
      hold_pend = out_valid && !out_ready && !redirect_vld;
      hold_addr = out_addr;
      hold_data = out_data;
      if (out_valid && out_ready) begin
        chk(out_addr == exp_addr, "R5 stream address", out_addr, exp_addr);
        chk(out_data == mkdata(exp_addr), "R2 word data", out_data, mkdata(exp_addr));
        exp_addr = exp_addr + 1'b1;
      end
      reqs_since += int'(even_req) + int'(odd_req);
      if (redirect_vld) begin
        exp_addr = redirect_addr;
        reqs_since = 0;
      end
      prev_req = {odd_req, even_req};
    end else begin
      chk(!out_valid, "R1 valid during reset", out_valid, 0);
      prev_req = '0;
    end
  endtask

  task automatic jump_timed(input logic [15:0] t, input string tag);
    nx_ready = 1'b1; nx_redir = 1'b1; nx_addr = t;
    tick();
    nx_redir = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk(!out_valid, "R8 flushed output", out_valid, 0);
    end
    tick();
    chk(out_valid && out_addr == t, {tag, " first word after redirect (R4)"}, {out_valid, out_addr}, {1'b1, t});
    for (int k = 0; k < 8; k++) begin
      tick();
      chk(out_valid, {tag, " one word per cycle"}, out_valid, 1);
    end
  endtask

  initial begin
    nx_ready = 1'b1;
    repeat (3) tick();
    // R1: release reset, start vector arrives three cycles later
    nx_rst = 1'b1;
    tick();
    chk(!out_valid, "R1 release cycle", out_valid, 0);
    for (int k = 1; k <= 2; k++) begin
      tick();
      chk(!out_valid, "R1 early valid", out_valid, 0);
    end
    tick();
    chk(out_valid && out_addr == RV, "R1 start vector", {out_valid, out_addr}, {1'b1, RV});
    repeat (10) tick();

    jump_timed(16'h2000, "R5");
    jump_timed(16'h3131, "R6");

    // R9: redirect twice in a row while words are in flight
    nx_redir = 1'b1; nx_addr = 16'h0400;
    tick();
    nx_addr = 16'h0777;
    tick();
    nx_redir = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk(!out_valid, "R9 stale word", out_valid, 0);
    end
    tick();
    chk(out_valid && out_addr == 16'h0777, "R9 second target wins", {out_valid, out_addr}, {1'b1, 16'h0777});
    repeat (6) tick();

    // R7: core stalls, fetch stops at the FIFO depth
    nx_ready = 1'b0; nx_redir = 1'b1; nx_addr = 16'h5002;
    tick();
    nx_redir = 1'b0;
    repeat (12) tick();
    chk(reqs_since == 4, "R7 fetches while stalled", reqs_since, 4);
    chk(out_valid && out_addr == 16'h5002, "R7 head word held", {out_valid, out_addr}, {1'b1, 16'h5002});
    nx_ready = 1'b1;
    repeat (12) tick();
    chk(exp_addr >= 16'h500A, "R7 stream resumed", exp_addr, 16'h500A);

    // mixed traffic: random ready and occasional redirects
    for (int n = 0; n < 4000; n++) begin
      nx_ready = ($urandom_range(3) != 0);
      nx_redir = ($urandom_range(40) == 0);
      nx_addr  = 16'($urandom);
      tick();
    end
    nx_redir = 1'b0;
    repeat (8) tick();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule